// File: doc/BRIEF.md
# PCI Interrupt Router with Slot Swizzle

This block collects the four level-sensitive interrupt pins (INTA to INTD) of up to `NUM_DEV` PCI devices. It rotates each device's pins by that device's slot number and folds them onto four shared interrupt lines, PIRQ A to PIRQ D. Four route registers then send each PIRQ line to one of sixteen ISA interrupt request outputs. An output is the wired-OR of every PIRQ line routed to it. A route register can also take its PIRQ line out of service.

Two trigger-mode registers each hold one bit per ISA IRQ. A set bit marks that IRQ as level-triggered. They are presented on `trig_level` for the downstream interrupt controller. A small register port writes and reads all six registers. A common setup sends PIRQ A to D to IRQ 11, 9, 11 and 9, with IRQs 9 and 11 set to level mode. The IRQ levels are computed combinationally from the current inputs and route registers, then registered once before they leave the block.

Top module: `pirq_router`

## Requirements
- R1: Pin p of a device (INTA=0, INTB=1, INTC=2, INTD=3) drives PIRQ line (p + slot − 1) mod 4, where slot is the full `SLOT_W`-bit device number. A slot of 0 therefore rotates INTA onto PIRQ D.
- R2: A PIRQ line is the OR of every device pin rotated onto it. It stays active while any one of those pins is still high.
- R3: Selector values 0, 1, 2 and 3 write and read the route registers of PIRQ A, B, C and D. All 8 bits are stored and read back. Bits 3:0 give the ISA IRQ number.
- R4: After reset, every route register reads 0x80, both trigger registers read 0x00, `irq_out` is 0, and no IRQ is driven even when every device pin is high.
- R5: A route register with bit 7 set drives no ISA IRQ, whatever its low bits hold.
- R6: A route register whose bits 3:0 name IRQ 0, 1, 2, 8 or 13 drives no ISA IRQ.
- R7: ISA IRQ k is the OR of every enabled PIRQ line whose route register names k. Two lines sharing an IRQ merge into it.
- R8: Selector 4 writes the trigger bits of IRQ 0 to 7, and selector 5 writes those of IRQ 8 to 15. IRQ k is bit k mod 8 of its register. `trig_level[k]` shows the stored bit, and 1 means level trigger.
- R9: A change on a device pin or in a route register reaches `irq_out` at the first clock edge after the change is in place, and not before.
- R10: Selector values 6 and 7 read as 0x00. Writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_int_lvl | input | NUM_DEV*4 | Pin levels, device d pin p at bit d*4+p |
| dev_slot | input | NUM_DEV*SLOT_W | Slot number of device d at bits d*SLOT_W +: SLOT_W |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register selector (0–3 route A–D, 4/5 trigger low/high) |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read data of the selected register, combinational |
| irq_out | output | 16 | Registered ISA IRQ levels |
| trig_level | output | 16 | Trigger mode per ISA IRQ, 1 = level |

## Verification
The bench targets the rotation wrap at slot 0 and at the top slot value. An off-by-one swizzle would light the neighbouring PIRQ's IRQ there. It holds one of two pins on a shared PIRQ while dropping the other, and sends two PIRQ lines to the same IRQ. A last-writer routing scheme, instead of an OR, would drop one of these sources. It programs disable-bit values and each reserved IRQ number, and a design that only checks bit 7 would drive a forbidden line. It also samples the cycle before an output is due, which catches a design with a missing register stage or an extra one.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int PIRQ_N    = 4;
    localparam int ISA_N     = 16;
    localparam int REG_W     = 8;
    localparam int IRQ_NUM_W = 4;
    localparam int DIS_BIT   = 7;
    localparam int SEL_W     = 3;

    // IRQ numbers that may never be driven: 0, 1, 2, 8, 13
    localparam logic [ISA_N-1:0] RESV_IRQ_MASK = 16'h2107;
    localparam logic [REG_W-1:0] ROUTE_RST     = 8'h80;

    typedef enum logic [SEL_W-1:0] {
        SEL_PIRQ_A  = 3'd0,
        SEL_PIRQ_B  = 3'd1,
        SEL_PIRQ_C  = 3'd2,
        SEL_PIRQ_D  = 3'd3,
        SEL_TRIG_LO = 3'd4,
        SEL_TRIG_HI = 3'd5
    } cfg_sel_e;

    typedef logic [REG_W-1:0] route_t;

    typedef struct packed {
        route_t [PIRQ_N-1:0] route;
        logic   [ISA_N-1:0]  trig;
        logic   [ISA_N-1:0]  irq;
    } rtr_state_t;

endpackage

// File: rtl/pirq_swizzle.sv
module pirq_swizzle
    import pirq_pkg::*;
#(
    parameter int NUM_DEV = 8,
    parameter int SLOT_W  = 5
) (
    input  logic [NUM_DEV*PIRQ_N-1:0] pin_lvl,
    input  logic [NUM_DEV*SLOT_W-1:0] dev_slot,
    output logic [PIRQ_N-1:0]         pirq_lvl
);

    logic [NUM_DEV-1:0][PIRQ_N-1:0] dev_rot;

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        logic [1:0]        shift;
        logic [PIRQ_N-1:0] rot;

        // slot - 1 modulo 4, written as slot + 3 so slot 0 wraps cleanly
        assign shift = 2'((dev_slot[d*SLOT_W +: SLOT_W] + SLOT_W'(PIRQ_N - 1))
                          % SLOT_W'(PIRQ_N));

        always_comb begin
            rot = '0;
            for (int p = 0; p < PIRQ_N; p++) begin
                rot[2'(p) + shift] = pin_lvl[d*PIRQ_N + p];
            end
        end

        assign dev_rot[d] = rot;
    end

    always_comb begin
        pirq_lvl = '0;
        for (int d = 0; d < NUM_DEV; d++) begin
            pirq_lvl = pirq_lvl | dev_rot[d];
        end
    end

endmodule

// File: rtl/pirq_map.sv
module pirq_map
    import pirq_pkg::*;
(
    input  logic [PIRQ_N-1:0]                pirq_lvl,
    input  logic [PIRQ_N-1:0]                route_off,
    input  logic [PIRQ_N-1:0][IRQ_NUM_W-1:0] route_num,
    output logic [ISA_N-1:0]                 isa_lvl
);

    logic [PIRQ_N-1:0] live;

    for (genvar i = 0; i < PIRQ_N; i++) begin : g_line
        assign live[i] = pirq_lvl[i] & ~route_off[i] & ~RESV_IRQ_MASK[route_num[i]];
    end

    for (genvar k = 0; k < ISA_N; k++) begin : g_isa
        logic [PIRQ_N-1:0] hit;
        for (genvar i = 0; i < PIRQ_N; i++) begin : g_cmp
            assign hit[i] = live[i] && (route_num[i] == IRQ_NUM_W'(k));
        end
        assign isa_lvl[k] = |hit;
    end

endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_pkg::*;
#(
    parameter int NUM_DEV = 8,
    parameter int SLOT_W  = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_DEV*4-1:0]      dev_int_lvl,
    input  logic [NUM_DEV*SLOT_W-1:0] dev_slot,
    input  logic                      cfg_wr,
    input  logic [2:0]                cfg_sel,
    input  logic [7:0]                cfg_wdata,
    output logic [7:0]                cfg_rdata,
    output logic [15:0]               irq_out,
    output logic [15:0]               trig_level
);

    localparam int HALF = ISA_N / 2;

    rtr_state_t st_d, st_q;

    logic [PIRQ_N-1:0]                pirq_lvl;
    logic [PIRQ_N-1:0]                route_off;
    logic [PIRQ_N-1:0][IRQ_NUM_W-1:0] route_num;
    logic [ISA_N-1:0]                 isa_lvl;
    logic [PIRQ_N-1:0][REG_W-1:0]     route_cur;

    for (genvar i = 0; i < PIRQ_N; i++) begin : g_fields
        assign route_off[i] = st_q.route[i][DIS_BIT];
        assign route_num[i] = st_q.route[i][IRQ_NUM_W-1:0];
    end

    assign route_cur = st_q.route;

    pirq_swizzle #(
        .NUM_DEV (NUM_DEV),
        .SLOT_W  (SLOT_W)
    ) u_swizzle (
        .pin_lvl  (dev_int_lvl),
        .dev_slot (dev_slot),
        .pirq_lvl (pirq_lvl)
    );

    pirq_map u_map (
        .pirq_lvl  (pirq_lvl),
        .route_off (route_off),
        .route_num (route_num),
        .isa_lvl   (isa_lvl)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = isa_lvl;
        if (cfg_wr) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_PIRQ_A, SEL_PIRQ_B, SEL_PIRQ_C, SEL_PIRQ_D:
                    st_d.route[cfg_sel[1:0]] = cfg_wdata;
                SEL_TRIG_LO: st_d.trig[HALF-1:0]     = cfg_wdata;
                SEL_TRIG_HI: st_d.trig[ISA_N-1:HALF] = cfg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.route <= {PIRQ_N{ROUTE_RST}};
            st_q.trig  <= '0;
            st_q.irq   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (cfg_sel_e'(cfg_sel))
            SEL_PIRQ_A, SEL_PIRQ_B, SEL_PIRQ_C, SEL_PIRQ_D:
                cfg_rdata = st_q.route[cfg_sel[1:0]];
            SEL_TRIG_LO: cfg_rdata = st_q.trig[HALF-1:0];
            SEL_TRIG_HI: cfg_rdata = st_q.trig[ISA_N-1:HALF];
            default:     cfg_rdata = '0;
        endcase
    end

    assign irq_out    = st_q.irq;
    assign trig_level = st_q.trig;

endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
    parameter int NUM_DEV = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_DEV*4-1:0] dev_int_lvl,
    input logic                 cfg_wr,
    input logic [2:0]           cfg_sel,
    input logic [7:0]           cfg_wdata,
    input logic [15:0]          irq_out,
    input logic [15:0]          trig_level,
    input logic [3:0][7:0]      route
);

    AST_ROUTE_A_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel == 3'd0) |=> route[0] == $past(cfg_wdata)); // R3

    AST_TRIG_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel == 3'd5) |=> trig_level[15:8] == $past(cfg_wdata)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_int_lvl == '0) |=> irq_out == '0); // R2

    AST_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (route[0][7] && route[1][7] && route[2][7] && route[3][7]) |=> irq_out == '0); // R5

    AST_RESV_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & 16'h2107) == '0); // R6

    AST_FANOUT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq_out) <= 4); // R7

    AST_UNUSED_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel > 3'd5) |=> ($stable(route) && $stable(trig_level))); // R10

endmodule

bind pirq_router pirq_router_chk #(
    .NUM_DEV (NUM_DEV)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dev_int_lvl (dev_int_lvl),
    .cfg_wr      (cfg_wr),
    .cfg_sel     (cfg_sel),
    .cfg_wdata   (cfg_wdata),
    .irq_out     (irq_out),
    .trig_level  (trig_level),
    .route       (route_cur)
);

// File: tb/pirq_router_bench.sv
module pirq_router_bench;

    localparam int NUM_DEV = 8;
    localparam int SLOT_W  = 5;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic [NUM_DEV*4-1:0]      dev_int_lvl = '0;
    logic [NUM_DEV*SLOT_W-1:0] dev_slot = '0;
    logic                      cfg_wr = 1'b0;
    logic [2:0]                cfg_sel = '0;
    logic [7:0]                cfg_wdata = '0;
    logic [7:0]                cfg_rdata;
    logic [15:0]               irq_out;
    logic [15:0]               trig_level;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pirq_router #(
        .NUM_DEV (NUM_DEV),
        .SLOT_W  (SLOT_W)
    ) u_pirq_router (
        .clk         (clk),
        .rst_n       (rst_n),
        .dev_int_lvl (dev_int_lvl),
        .dev_slot    (dev_slot),
        .cfg_wr      (cfg_wr),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .irq_out     (irq_out),
        .trig_level  (trig_level)
    );

    // ---------------- behavioural reference ----------------
    int unsigned m_route [4];
    int unsigned m_trig;
    logic [15:0] m_exp;

    function automatic logic [15:0] ref_irq(logic [NUM_DEV*4-1:0] lvl,
                                            logic [NUM_DEV*SLOT_W-1:0] slots);
        int pir [4];
        logic [15:0] res;
        res = '0;
        for (int i = 0; i < 4; i++) pir[i] = 0;
        for (int d = 0; d < NUM_DEV; d++) begin
            int s;
            s = int'(slots[d*SLOT_W +: SLOT_W]);
            for (int p = 0; p < 4; p++)
                if (lvl[d*4+p]) pir[(p + s + 3) % 4] = 1;
        end
        for (int i = 0; i < 4; i++) begin
            int r, n;
            r = int'(m_route[i]);
            n = r % 16;
            if (r < 128 && pir[i] != 0 && !(n inside {0, 1, 2, 8, 13}))
                res[n] = 1'b1;
        end
        return res;
    endfunction

    function automatic logic [7:0] ref_read(logic [2:0] sel);
        if (sel < 3'd4) return 8'(m_route[sel]);
        if (sel == 3'd4) return 8'(m_trig % 256);
        if (sel == 3'd5) return 8'(m_trig / 256);
        return 8'h00;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_route[i] <= 32'h80;
            m_trig <= 0;
            m_exp  <= '0;
        end else begin
            m_exp <= ref_irq(dev_int_lvl, dev_slot);
            if (cfg_wr) begin
                if (cfg_sel < 3'd4) m_route[cfg_sel] <= 32'(cfg_wdata);
                else if (cfg_sel == 3'd4) m_trig <= (m_trig & 32'hFF00) | 32'(cfg_wdata);
                else if (cfg_sel == 3'd5) m_trig <= (m_trig & 32'h00FF) | (32'(cfg_wdata) << 8);
            end
        end
    end

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R7/R9 cycle model irq_out", irq_out, m_exp);
            chk("R8 cycle model trig_level", trig_level, 16'(m_trig));
            chk("R3 cycle model cfg_rdata", 16'(cfg_rdata), 16'(ref_read(cfg_sel)));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic settle();
        step();
        step();
        @(negedge clk);
    endtask

    task automatic cfg_write(logic [2:0] sel, logic [7:0] val);
        cfg_sel   = sel;
        cfg_wdata = val;
        cfg_wr    = 1'b1;
        step();
        cfg_wr    = 1'b0;
    endtask

    task automatic read_chk(string req, logic [2:0] sel, logic [7:0] exp);
        cfg_sel = sel;
        #1;
        chk(req, 16'(cfg_rdata), 16'(exp));
    endtask

    task automatic set_slot(int d, int s);
        dev_slot[d*SLOT_W +: SLOT_W] = SLOT_W'(s);
    endtask

    task automatic pins(logic [NUM_DEV*4-1:0] v);
        dev_int_lvl = v;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired, actual=running expected=finished");
            done = 1;
            summary();
            $finish;
        end
    end

    initial begin
        // R4: reset state
        repeat (3) @(negedge clk);
        chk("R4 irq_out in reset", irq_out, 16'h0000);
        chk("R4 trig_level in reset", trig_level, 16'h0000);
        for (int i = 0; i < 4; i++) read_chk("R4 route reset value", 3'(i), 8'h80);
        read_chk("R4 trig low reset", 3'd4, 8'h00);
        step();
        rst_n = 1'b1;
        pins('1);
        settle();
        chk("R4 all pins high, routes disabled after reset", irq_out, 16'h0000);
        pins('0);

        // R3: distinct routes A..D -> 3,4,5,6
        cfg_write(3'd0, 8'h03);
        cfg_write(3'd1, 8'h04);
        cfg_write(3'd2, 8'h05);
        cfg_write(3'd3, 8'h06);
        read_chk("R3 route B readback", 3'd1, 8'h04);

        // R8: trigger registers
        cfg_write(3'd5, 8'h0A);
        cfg_write(3'd4, 8'h20);
        @(negedge clk);
        chk("R8 trig IRQ5,9,11", trig_level, 16'h0A20);
        cfg_write(3'd4, 8'h00);
        @(negedge clk);
        chk("R8 trig low cleared", trig_level, 16'h0A00);

        // R9: latency, R1 rotation
        set_slot(0, 1);
        step();
        pins(32'h0000_0001);
        @(negedge clk);
        chk("R9 no change before edge", irq_out, 16'h0000);
        @(negedge clk);
        chk("R9/R1 slot1 INTA -> PIRQ A -> IRQ3", irq_out, 16'h0008);

        set_slot(0, 2);
        settle();
        chk("R1 slot2 INTA -> PIRQ B -> IRQ4", irq_out, 16'h0010);
        set_slot(0, 0);
        settle();
        chk("R1 slot0 INTA wraps to PIRQ D -> IRQ6", irq_out, 16'h0040);
        set_slot(0, 7);
        pins(32'h0000_0004);
        settle();
        chk("R1 slot7 INTC -> PIRQ A -> IRQ3", irq_out, 16'h0008);
        set_slot(0, 31);
        pins(32'h0000_0002);
        settle();
        chk("R1 slot31 INTB -> PIRQ D -> IRQ6", irq_out, 16'h0040);
        set_slot(1, 5);
        pins(32'h0000_0080);
        settle();
        chk("R1 dev1 slot5 INTD -> PIRQ D -> IRQ6", irq_out, 16'h0040);

        // R2: two pins on PIRQ A
        set_slot(0, 1);
        set_slot(1, 2);
        pins(32'h0000_0081);
        settle();
        chk("R2 two pins on PIRQ A", irq_out, 16'h0008);
        pins(32'h0000_0080);
        settle();
        chk("R2 one pin still holds PIRQ A", irq_out, 16'h0008);
        pins(32'h0000_0000);
        settle();
        chk("R2 all pins low", irq_out, 16'h0000);

        // R7: typical routing 11,9,11,9
        cfg_write(3'd0, 8'h0B);
        cfg_write(3'd1, 8'h09);
        cfg_write(3'd2, 8'h0B);
        cfg_write(3'd3, 8'h09);
        pins(32'h0000_0001);
        settle();
        chk("R7 PIRQ A alone -> IRQ11", irq_out, 16'h0800);
        pins(32'h0000_0004);
        settle();
        chk("R7 PIRQ C alone -> IRQ11", irq_out, 16'h0800);
        pins(32'h0000_0005);
        settle();
        chk("R7 A and C merged on IRQ11", irq_out, 16'h0800);
        pins(32'h0000_0003);
        settle();
        chk("R7 A and B -> IRQ11 and IRQ9", irq_out, 16'h0A00);

        // R5: disable bit
        pins(32'h0000_0001);
        cfg_write(3'd0, 8'h8B);
        settle();
        chk("R5 bit7 disables PIRQ A", irq_out, 16'h0000);
        read_chk("R5 disabled route readback", 3'd0, 8'h8B);

        // R6: reserved IRQ numbers
        cfg_write(3'd0, 8'h0D);
        settle();
        chk("R6 IRQ13 blocked", irq_out, 16'h0000);
        cfg_write(3'd0, 8'h02);
        settle();
        chk("R6 IRQ2 blocked", irq_out, 16'h0000);
        cfg_write(3'd0, 8'h08);
        settle();
        chk("R6 IRQ8 blocked", irq_out, 16'h0000);
        cfg_write(3'd0, 8'h00);
        settle();
        chk("R6 IRQ0 blocked", irq_out, 16'h0000);
        cfg_write(3'd0, 8'h01);
        settle();
        chk("R6 IRQ1 blocked", irq_out, 16'h0000);
        cfg_write(3'd0, 8'h03);
        settle();
        chk("R6 IRQ3 allowed", irq_out, 16'h0008);

        // R3: full byte kept, low nibble routes
        cfg_write(3'd0, 8'h7E);
        settle();
        chk("R3 0x7E routes to IRQ14", irq_out, 16'h4000);
        read_chk("R3 full byte readback", 3'd0, 8'h7E);

        // R10: unused selectors
        cfg_write(3'd6, 8'h03);
        cfg_write(3'd7, 8'hFF);
        settle();
        chk("R10 irq unchanged after unused writes", irq_out, 16'h4000);
        chk("R10 trig unchanged after unused writes", trig_level, 16'h0A00);
        read_chk("R10 sel6 reads zero", 3'd6, 8'h00);
        read_chk("R10 sel7 reads zero", 3'd7, 8'h00);
        read_chk("R10 route A intact", 3'd0, 8'h7E);

        // random traffic, compared every cycle by the model
        for (int n = 0; n < 600; n++) begin
            dev_int_lvl = ($urandom % 3 == 0) ? '0 : 32'($urandom & $urandom);
            if (n % 17 == 0)
                for (int d = 0; d < NUM_DEV; d++) set_slot(d, int'($urandom % 32));
            if ($urandom % 4 == 0) begin
                cfg_sel   = 3'($urandom % 8);
                cfg_wdata = ($urandom % 2 == 0) ? 8'($urandom % 16) : 8'($urandom);
                cfg_wr    = 1'b1;
            end else begin
                cfg_wr  = 1'b0;
                cfg_sel = 3'($urandom % 8);
            end
            step();
        end
        cfg_wr = 1'b0;
        settle();

        done = 1;
        summary();
        $finish;
    end

endmodule